// File: doc/BRIEF.md
# Dual-Mode Three-Level Cell Sequencer

This block is a synchronous controller that runs one operation at a time on a three-level in-memory cell. The cell works either as a 2-bit quantizer of an analog input or as a 3-input logic evaluator. A mode input selects which of the two it is. A single start pulse launches the operation, and the controller then steps through three fixed phases: wipe, drive and read-out. The wipe phase is the same in both modes. The drive phase samples the input in quantize mode and lets the input currents compute in logic mode.

During read-out the controller precharges for one cycle and then senses. On the last sense cycle it captures the three level bits the cell returns. A valid capture is a thermometer pattern. The block decodes it into a 2-bit code and also presents the raw bits as OR, majority and AND results. A capture that is not a thermometer pattern raises an error flag, and that operation's code is forced to zero. The analog device and the sense path sit outside the block. The bench stands in for them with a behavioural model.

Top module: `triLevelSeq`

## Requirements
- R1: An accepted start is followed by 3 wipe cycles, then 5 drive cycles, then 2 read cycles. Done comes in the cycle right after the last read cycle, 11 cycles after the clock edge that accepted the start.
- R2: In every wipe cycle wipeStrobe=1, wrEn=1, bitLine=1 and rdEn=0.
- R3: In every drive cycle wipeStrobe=0, wrEn=1, bitLine=0 and rdEn=0.
- R4: sampleStrobe is 1 only in the first drive cycle, and only when quantMode was 1 at the accepted start. The mode is latched at that start; later changes to quantMode have no effect on the running operation.
- R5: In both read cycles wrEn=0 and bitLine=0. rdEn is 0 in the first read cycle (precharge) and 1 in the second (sense).
- R6: While idle, and from reset, wrEn, rdEn, bitLine, wipeStrobe and sampleStrobe are all 0. busy, done, code, codeErr and the three logic outputs reset to 0.
- R7: The level bits are cellLevels[0]=L0, cellLevels[1]=L1 and cellLevels[2]=L2, all sampled together on the sense cycle. Patterns {L2,L1,L0} = 000, 001, 011 and 111 give code 00, 01, 10 and 11.
- R8: orOut=L0, majOut=L1 and andOut=L2 of the captured bits. This gives OR, majority and AND of A, B and C. With C=0 the outputs give OR(A,B) on orOut and AND(A,B) on majOut.
- R9: Any captured pattern other than the four thermometer patterns (for example L1 alone, or L0 with L2) sets codeErr=1 and code=00 for that operation. A valid capture clears codeErr.
- R10: busy is 1 from the cycle after the accepted start through the last read cycle, and 0 in the done cycle. A start received while busy is ignored.
- R11: done is a single-cycle pulse. code, codeErr and the logic outputs change only in the cycle where done is 1, and they hold their values until the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opStart | input | 1 | Start pulse, accepted only when idle |
| quantMode | input | 1 | 1 = quantize operation, 0 = logic operation |
| cellLevels | input | 3 | Level bits from the sense path, bit 0 = L0 |
| wrEn | output | 1 | Write enable to the cell |
| rdEn | output | 1 | Read enable: 0 precharge, 1 sense |
| bitLine | output | 1 | Bit-line drive |
| wipeStrobe | output | 1 | Pushes the cell back to its starting position |
| sampleStrobe | output | 1 | Brief analog sample strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are registered |
| code | output | 2 | Quantized code |
| codeErr | output | 1 | Captured pattern was not a thermometer code |
| orOut | output | 1 | OR result (L0) |
| majOut | output | 1 | Majority result (L1) |
| andOut | output | 1 | AND result (L2) |

## Verification
Counting from the clock edge that accepts a start, the strobes and busy for cycle k (1 to 10) are valid after edge k-1. The results and done are valid after edge 10, and done has dropped after edge 11. The driver task compares the strobes and busy on the falling edge of each of cycles 1 to 10, checks busy and done in cycles 11 and 12, and pushes the expected result into a queue before the start. A monitor pops that item on the falling edge where done is high, so each result is compared exactly in its due cycle.

// File: rtl/triLevelPkg.sv
package triLevelPkg;

  localparam int LEVELS = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WIPE  = 2'd1,
    PH_DRIVE = 2'd2,
    PH_READ  = 2'd3
  } phase_t;

  typedef struct packed {
    logic wipe;
    logic write;
    logic read;
    logic bitLine;
    logic sample;
    logic capture;
  } strobes_t;

endpackage

// File: rtl/triLevelCtrl.sv
module triLevelCtrl
  import triLevelPkg::*;
#(
  parameter int WIPE_CYCLES      = 3,
  parameter int DRIVE_CYCLES     = 5,
  parameter int READ_CYCLES      = 2,
  parameter int PRECHARGE_CYCLES = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     opStart,
  input  logic     quantMode,
  output strobes_t strb,
  output logic     busy,
  output logic     done
);

  localparam int MAX_A   = (WIPE_CYCLES > DRIVE_CYCLES) ? WIPE_CYCLES : DRIVE_CYCLES;
  localparam int MAX_CYC = (MAX_A > READ_CYCLES) ? MAX_A : READ_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  localparam logic [CNT_W-1:0] WIPE_LAST  = CNT_W'(WIPE_CYCLES - 1);
  localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(DRIVE_CYCLES - 1);
  localparam logic [CNT_W-1:0] READ_LAST  = CNT_W'(READ_CYCLES - 1);
  localparam logic [CNT_W-1:0] SENSE_FROM = CNT_W'(PRECHARGE_CYCLES);

  phase_t           phase;
  logic [CNT_W-1:0] phaseCnt;
  logic             quantLatched;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase        <= PH_IDLE;
      phaseCnt     <= '0;
      quantLatched <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (opStart) begin
            phase        <= PH_WIPE;
            phaseCnt     <= '0;
            quantLatched <= quantMode;
            busy         <= 1'b1;
          end
        end
        PH_WIPE: begin
          if (phaseCnt == WIPE_LAST) begin
            phase    <= PH_DRIVE;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_DRIVE: begin
          if (phaseCnt == DRIVE_LAST) begin
            phase    <= PH_READ;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_READ: begin
          if (phaseCnt == READ_LAST) begin
            phase    <= PH_IDLE;
            phaseCnt <= '0;
            busy     <= 1'b0;
            done     <= 1'b1;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    unique case (phase)
      PH_WIPE: begin
        strb.wipe    = 1'b1;
        strb.write   = 1'b1;
        strb.bitLine = 1'b1;
      end
      PH_DRIVE: begin
        strb.write  = 1'b1;
        strb.sample = quantLatched && (phaseCnt == '0);
      end
      PH_READ: begin
        strb.read    = (phaseCnt >= SENSE_FROM);
        strb.capture = (phaseCnt == READ_LAST);
      end
      default: strb = '0;
    endcase
  end

endmodule

// File: rtl/triLevelPath.sv
module triLevelPath
  import triLevelPkg::*;
#(
  parameter int NUM_LEVELS = LEVELS,
  localparam int CODE_W = $clog2(NUM_LEVELS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              strb,
  input  logic [NUM_LEVELS-1:0] cellLevels,
  output logic                  wrEn,
  output logic                  rdEn,
  output logic                  bitLine,
  output logic                  wipeStrobe,
  output logic                  sampleStrobe,
  output logic [CODE_W-1:0]     code,
  output logic                  codeErr,
  output logic [NUM_LEVELS-1:0] levelBits
);

  assign wrEn         = strb.write;
  assign rdEn         = strb.read;
  assign bitLine      = strb.bitLine;
  assign wipeStrobe   = strb.wipe;
  assign sampleStrobe = strb.sample;

  logic [NUM_LEVELS:0] isTherm;
  logic [CODE_W-1:0]   thermIdx;
  logic                thermOk;

  for (genvar n = 0; n <= NUM_LEVELS; n++) begin : gThermMatch
    assign isTherm[n] = (cellLevels == NUM_LEVELS'((1 << n) - 1));
  end

  always_comb begin
    thermIdx = '0;
    for (int n = 0; n <= NUM_LEVELS; n++) begin
      if (isTherm[n]) thermIdx = thermIdx | CODE_W'(n);
    end
  end

  assign thermOk = |isTherm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code      <= '0;
      codeErr   <= 1'b0;
      levelBits <= '0;
    end else if (strb.capture) begin
      levelBits <= cellLevels;
      codeErr   <= !thermOk;
      code      <= thermOk ? thermIdx : '0;
    end
  end

endmodule

// File: rtl/triLevelSeq.sv
module triLevelSeq
  import triLevelPkg::*;
#(
  parameter int WIPE_CYCLES  = 3,
  parameter int DRIVE_CYCLES = 5,
  parameter int READ_CYCLES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opStart,
  input  logic       quantMode,
  input  logic [2:0] cellLevels,
  output logic       wrEn,
  output logic       rdEn,
  output logic       bitLine,
  output logic       wipeStrobe,
  output logic       sampleStrobe,
  output logic       busy,
  output logic       done,
  output logic [1:0] code,
  output logic       codeErr,
  output logic       orOut,
  output logic       majOut,
  output logic       andOut
);

  strobes_t   strb;
  logic [2:0] levelBits;

  triLevelCtrl #(
    .WIPE_CYCLES     (WIPE_CYCLES),
    .DRIVE_CYCLES    (DRIVE_CYCLES),
    .READ_CYCLES     (READ_CYCLES),
    .PRECHARGE_CYCLES(1)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opStart  (opStart),
    .quantMode(quantMode),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  triLevelPath #(
    .NUM_LEVELS(3)
  ) path (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cellLevels  (cellLevels),
    .wrEn        (wrEn),
    .rdEn        (rdEn),
    .bitLine     (bitLine),
    .wipeStrobe  (wipeStrobe),
    .sampleStrobe(sampleStrobe),
    .code        (code),
    .codeErr     (codeErr),
    .levelBits   (levelBits)
  );

  assign orOut  = levelBits[0];
  assign majOut = levelBits[1];
  assign andOut = levelBits[2];

endmodule

// File: rtl/triLevelChk.sv
module triLevelChk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic       bitLine,
  input logic       wipeStrobe,
  input logic       sampleStrobe,
  input logic       busy,
  input logic       done,
  input logic [1:0] code,
  input logic       codeErr,
  input logic       orOut,
  input logic       majOut,
  input logic       andOut
);

  assert_wipe_pattern_R2: assert property (@(posedge clk) disable iff (!rstN)
    wipeStrobe |-> (wrEn && bitLine && !rdEn && !sampleStrobe));

  assert_sample_drive_R3: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> (wrEn && !bitLine && !rdEn && !wipeStrobe));

  assert_sample_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> $past(wipeStrobe));

  assert_read_nowrite_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (!wrEn && !bitLine && !wipeStrobe));

  assert_sense_then_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdEn) |-> done);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!wrEn && !rdEn && !bitLine && !wipeStrobe && !sampleStrobe));

  assert_busy_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_hold_results_R11: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(code) && $stable(codeErr) && $stable(orOut)
               && $stable(majOut) && $stable(andOut)));

  assert_err_zero_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |-> (code == 2'b00));

endmodule

bind triLevelSeq triLevelChk chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .rdEn        (rdEn),
  .bitLine     (bitLine),
  .wipeStrobe  (wipeStrobe),
  .sampleStrobe(sampleStrobe),
  .busy        (busy),
  .done        (done),
  .code        (code),
  .codeErr     (codeErr),
  .orOut       (orOut),
  .majOut      (majOut),
  .andOut      (andOut)
);

// File: tb/triLevelSeq_test.sv
`timescale 1ns/1ps
module triLevelSeq_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       opStart;
  logic       quantMode;
  logic [2:0] cellLevels;
  logic       wrEn, rdEn, bitLine, wipeStrobe, sampleStrobe;
  logic       busy, done;
  logic [1:0] code;
  logic       codeErr, orOut, majOut, andOut;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  triLevelSeq uut (
    .clk(clk), .rstN(rstN), .opStart(opStart), .quantMode(quantMode),
    .cellLevels(cellLevels), .wrEn(wrEn), .rdEn(rdEn), .bitLine(bitLine),
    .wipeStrobe(wipeStrobe), .sampleStrobe(sampleStrobe), .busy(busy),
    .done(done), .code(code), .codeErr(codeErr), .orOut(orOut),
    .majOut(majOut), .andOut(andOut)
  );

  // behavioural cell: wall position 0..3, thermometer readout on sense
  int         mdlPos = 0;
  int         mdlAnalog = 0;
  logic       mdlQuant = 1'b0;
  logic       mdlA = 0, mdlB = 0, mdlC = 0;
  logic       mdlBadEn = 1'b0;
  logic [2:0] mdlBadPat = 3'b000;

  function automatic logic [2:0] therm(input int pos);
    return {pos >= 3, pos >= 2, pos >= 1};
  endfunction

  always @(posedge clk) begin
    if (wipeStrobe) mdlPos <= 0;
    else if (wrEn && !bitLine) begin
      if (sampleStrobe) mdlPos <= mdlAnalog;
      else if (!mdlQuant) mdlPos <= int'(mdlA) + int'(mdlB) + int'(mdlC);
    end
  end

  assign cellLevels = !rdEn ? 3'b000 : (mdlBadEn ? mdlBadPat : therm(mdlPos));

  typedef struct packed {
    logic [1:0] code;
    logic       err;
    logic       o;
    logic       m;
    logic       a;
  } result_t;

  result_t expQ[$];
  result_t lastExp = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: compares results in the cycle done is high
  initial begin
    forever begin
      @(negedge clk);
      if (rstN === 1'b1 && done === 1'b1) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R11", "unexpected done", 1, 0);
        end else begin
          result_t e;
          result_t got;
          e   = expQ.pop_front();
          got = '{code: code, err: codeErr, o: orOut, m: majOut, a: andOut};
          check(got.code == e.code, "R7", "code", got.code, e.code);
          check(got.err == e.err, "R9", "codeErr", got.err, e.err);
          check({got.o, got.m, got.a} == {e.o, e.m, e.a}, "R8",
                "or/maj/and", {got.o, got.m, got.a}, {e.o, e.m, e.a});
        end
      end
    end
  end

  // driver: one operation with per-cycle strobe checks
  task automatic runOp(input logic quant, input int analog,
                       input logic a, input logic b, input logic c,
                       input logic badEn, input logic [2:0] badPat,
                       input int glitchK);
    result_t e;
    logic [2:0] pat;
    mdlQuant  = quant;
    mdlAnalog = analog;
    mdlA = a; mdlB = b; mdlC = c;
    mdlBadEn  = badEn;
    mdlBadPat = badPat;
    if (badEn) begin
      e = '{code: 2'b00, err: 1'b1, o: badPat[0], m: badPat[1], a: badPat[2]};
    end else if (quant) begin
      pat = therm(analog);
      e = '{code: 2'(analog), err: 1'b0, o: pat[0], m: pat[1], a: pat[2]};
    end else begin
      e.o    = a | b | c;
      e.m    = (a & b) | (a & c) | (b & c);
      e.a    = a & b & c;
      e.err  = 1'b0;
      e.code = 2'(int'(e.o) + int'(e.m) + int'(e.a));
    end
    expQ.push_back(e);
    quantMode = quant;
    opStart   = 1'b1;
    @(negedge clk);
    quantMode = !quant;   // R4: mode must stay latched
    for (int k = 1; k <= 10; k++) begin
      logic [4:0] expStrb;  // {wipe, wr, rd, bl, smp}
      if (k <= 3)      expStrb = 5'b11010;
      else if (k == 4) expStrb = {4'b0100, quant};
      else if (k <= 8) expStrb = 5'b01000;
      else if (k == 9) expStrb = 5'b00000;
      else             expStrb = 5'b00100;
      check({wipeStrobe, wrEn, rdEn, bitLine, sampleStrobe} == expStrb,
            (k <= 3) ? "R2" : (k <= 8) ? ((k == 4) ? "R4" : "R3") : "R5",
            $sformatf("strobes cycle %0d", k),
            {wipeStrobe, wrEn, rdEn, bitLine, sampleStrobe}, expStrb);
      check(busy == 1'b1, "R10", $sformatf("busy cycle %0d", k), busy, 1);
      check(done == 1'b0, "R1", $sformatf("early done cycle %0d", k), done, 0);
      opStart = (k == glitchK);
      @(negedge clk);
    end
    opStart = 1'b0;
    check(done == 1'b1, "R1", "done on cycle 11", done, 1);
    check(busy == 1'b0, "R10", "busy in done cycle", busy, 0);
    @(negedge clk);
    check({done, busy} == 2'b00, "R11", "done/busy after pulse", {done, busy}, 0);
    lastExp = e;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; opStart = 1'b0; quantMode = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({wrEn, rdEn, bitLine, wipeStrobe, sampleStrobe} == 5'b0, "R6",
          "idle strobes after reset", {wrEn, rdEn, bitLine, wipeStrobe, sampleStrobe}, 0);
    check({busy, done, code, codeErr, orOut, majOut, andOut} == 8'b0, "R6",
          "reset outputs", {busy, done, code, codeErr, orOut, majOut, andOut}, 0);

    // R7: every quantize level
    for (int lv = 0; lv < 4; lv++) runOp(1'b1, lv, 0, 0, 0, 1'b0, 3'b000, 0);

    // R8: all three-input logic combinations
    for (int v = 0; v < 8; v++)
      runOp(1'b0, 0, v[2], v[1], v[0], 1'b0, 3'b000, 0);

    // R8: two-input with C tied low
    for (int v = 0; v < 4; v++)
      runOp(1'b0, 0, v[1], v[0], 1'b0, 1'b0, 3'b000, 0);

    // R9: non-thermometer captures in both modes, then recovery
    runOp(1'b1, 2, 0, 0, 0, 1'b1, 3'b010, 0);
    runOp(1'b0, 0, 1, 1, 0, 1'b1, 3'b101, 0);
    runOp(1'b1, 1, 0, 0, 0, 1'b1, 3'b100, 0);
    runOp(1'b1, 3, 0, 0, 0, 1'b0, 3'b000, 0);

    // R10: start pulses while busy are ignored
    runOp(1'b1, 2, 0, 0, 0, 1'b0, 3'b000, 2);
    runOp(1'b0, 0, 1, 0, 1, 1'b0, 3'b000, 9);

    // R11: results hold while idle
    repeat (4) @(negedge clk);
    check({code, codeErr, orOut, majOut, andOut} ==
          {lastExp.code, lastExp.err, lastExp.o, lastExp.m, lastExp.a}, "R11",
          "results hold idle", {code, codeErr, orOut, majOut, andOut},
          {lastExp.code, lastExp.err, lastExp.o, lastExp.m, lastExp.a});
    check(expQ.size() == 0, "R11", "results outstanding", expQ.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule